// File: doc/BRIEF.md
# Timer Compare Channel with Byte-Wide Register Access

This block pairs a 16-bit up-counter with one output compare channel. The counter steps forward on each cycle that the timer tick enable is high. On every such tick the channel compares the current count with a 16-bit compare value. When they are equal and no suppression is active, the channel sets a sticky match flag. It also changes an internal waveform bit as a 2-bit action field directs: leave the bit alone, toggle it, drive it low or drive it high.

Software reaches the block through an 8-bit register bus. The 16-bit quantities move one byte at a time through a single shared holding byte, so a compare value or a count is never seen half-updated. Software can apply the channel action to the waveform bit without a match by using a force strobe. A write to the counter suppresses the compare on the next tick, so software can load the counter with the compare value without producing a match.

Top module: `tmr_cmp_chan`

## Requirements
- R1: After reset the count, the compare value, the action field, the match flag and the waveform bit are all zero. Every register address reads zero.
- R2: The register map is: address 0 is the count low byte, 1 the count high byte, 2 the compare low byte, 3 the compare high byte, 4 the control byte and 5 the status byte. Writing a high byte (address 1 or 3) changes only the one shared holding byte. A later write of the compare low byte (address 2) loads the compare value as {holding byte, written byte} in a single clock. Compare bytes read back directly.
- R3: The count increases by one on each clock with tick high, wraps from 0xFFFF to 0x0000, and holds while tick is low. Writing the count low byte (address 0) loads {holding byte, written byte} and takes priority over a tick in the same clock.
- R4: Reading the count low byte (address 0 with the read strobe) returns the live low byte and copies the live high byte into the holding byte. A following read of address 1 returns that copy even if the counter has moved since.
- R5: On a clock where tick is high, the count equals the compare value and the compare is not suppressed, the match flag (status bit 0 and port `cmp_flag`) is high from the next clock on. Without tick, equality does not set the flag.
- R6: Writing status with bit 0 set clears the flag. Writing status with bit 0 clear leaves it unchanged.
- R7: Control bits [1:0] select the action on a match: 00 leaves the waveform bit unchanged, 01 toggles it, 10 clears it and 11 sets it. The new value appears on `wave_out` one clock after the matching tick.
- R8: Writing control with bit 2 set applies the action of the written bits [1:0] to the waveform bit one clock later. It does not set the flag and does not change the count. Bit 2 always reads back as 0.
- R9: A write to the count suppresses any match on the tick of that same clock and on the first tick after it, however many tickless clocks come between. The tick after that compares normally.
- R10: Loading the count with the compare value loses that match. The next match occurs only when the count comes back around, 0x10000 ticks later.
- R11: A write to the action field takes effect for a match or force in the same clock, with no buffering. Changing the action field does not by itself change the waveform bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Timer tick enable; counter advances and compares when high |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (needed to latch the count high byte) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the address |
| cmp_flag | output | 1 | Sticky match flag |
| wave_out | output | 1 | Internal waveform bit |

## Verification
Every register result is due one clock after the strobe that causes it. A match shows on `cmp_flag` and `wave_out` one clock after the tick clock in which the count equals the compare value. Because a counter load suppresses the next tick, a scenario that loads the count with one below the compare value reaches its match on exactly the second tick. The bench drives strobes and ticks on falling edges and samples outputs at the next falling edge, or 1 ns after an address change for combinational reads. Each expected value is therefore counted in whole ticks from the last load.

// File: rtl/tcc_pkg.sv
package tcc_pkg;

   typedef enum logic [1:0] {
      OCM_HOLD   = 2'b00,
      OCM_TOGGLE = 2'b01,
      OCM_CLEAR  = 2'b10,
      OCM_SET    = 2'b11
   } ocm_e;

   localparam int REG_AW = 3;

   localparam logic [REG_AW-1:0] RA_CNT_LO = 3'd0;
   localparam logic [REG_AW-1:0] RA_CNT_HI = 3'd1;
   localparam logic [REG_AW-1:0] RA_CMP_LO = 3'd2;
   localparam logic [REG_AW-1:0] RA_CMP_HI = 3'd3;
   localparam logic [REG_AW-1:0] RA_CTRL   = 3'd4;
   localparam logic [REG_AW-1:0] RA_STAT   = 3'd5;

   localparam int CTRL_FORCE_BIT = 2;
   localparam int STAT_FLAG_BIT  = 0;

   function automatic logic ocm_apply(input ocm_e m, input logic cur);
      case (m)
         OCM_TOGGLE: return ~cur;
         OCM_CLEAR:  return 1'b0;
         OCM_SET:    return 1'b1;
         default:    return cur;
      endcase
   endfunction

endpackage

// File: rtl/tcc_regif.sv
module tcc_regif
   import tcc_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int CNT_W  = 16
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [REG_AW-1:0]      bus_addr,
   input  logic                   bus_wr,
   input  logic                   bus_rd,
   input  logic [DATA_W-1:0]      bus_wdata,
   output logic [DATA_W-1:0]      bus_rdata,
   input  logic [CNT_W-1:0]       cnt,
   input  logic                   flag,
   output logic [CNT_W-1:0]       cmp_val,
   output ocm_e                   eff_mode,
   output logic                   cnt_wr,
   output logic [CNT_W-1:0]       cnt_wdata,
   output logic                   force_stb,
   output logic                   flag_clr
);

   localparam int HI_W = CNT_W - DATA_W;

   if (CNT_W != 2 * DATA_W) begin : g_bad_width
      $error("tcc_regif: CNT_W must be twice DATA_W");
   end
   if (DATA_W < 3) begin : g_bad_data
      $error("tcc_regif: DATA_W must hold the control fields");
   end

   logic [HI_W-1:0] hold_q;
   logic [CNT_W-1:0] cmp_q;
   ocm_e             mode_q;

   logic wr_cnt_lo, wr_cnt_hi, wr_cmp_lo, wr_cmp_hi, wr_ctrl, wr_stat, rd_cnt_lo;

   assign wr_cnt_lo = bus_wr && (bus_addr == RA_CNT_LO);
   assign wr_cnt_hi = bus_wr && (bus_addr == RA_CNT_HI);
   assign wr_cmp_lo = bus_wr && (bus_addr == RA_CMP_LO);
   assign wr_cmp_hi = bus_wr && (bus_addr == RA_CMP_HI);
   assign wr_ctrl   = bus_wr && (bus_addr == RA_CTRL);
   assign wr_stat   = bus_wr && (bus_addr == RA_STAT);
   assign rd_cnt_lo = bus_rd && !bus_wr && (bus_addr == RA_CNT_LO);

   // shared holding byte for both 16-bit registers, both directions
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q <= '0;
      end else if (wr_cnt_hi || wr_cmp_hi) begin
         hold_q <= bus_wdata[HI_W-1:0];
      end else if (rd_cnt_lo) begin
         hold_q <= cnt[CNT_W-1:DATA_W];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmp_q <= '0;
      end else if (wr_cmp_lo) begin
         cmp_q <= {hold_q, bus_wdata};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= OCM_HOLD;
      end else if (wr_ctrl) begin
         mode_q <= ocm_e'(bus_wdata[1:0]);
      end
   end

   // action bits act in the very clock they are written
   assign eff_mode  = wr_ctrl ? ocm_e'(bus_wdata[1:0]) : mode_q;
   assign force_stb = wr_ctrl && bus_wdata[CTRL_FORCE_BIT];
   assign flag_clr  = wr_stat && bus_wdata[STAT_FLAG_BIT];
   assign cnt_wr    = wr_cnt_lo;
   assign cnt_wdata = {hold_q, bus_wdata};
   assign cmp_val   = cmp_q;

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         RA_CNT_LO: bus_rdata = cnt[DATA_W-1:0];
         RA_CNT_HI: bus_rdata[HI_W-1:0] = hold_q;
         RA_CMP_LO: bus_rdata = cmp_q[DATA_W-1:0];
         RA_CMP_HI: bus_rdata[HI_W-1:0] = cmp_q[CNT_W-1:DATA_W];
         RA_CTRL:   bus_rdata[1:0] = mode_q;
         RA_STAT:   bus_rdata[STAT_FLAG_BIT] = flag;
         default:   bus_rdata = '0;
      endcase
   end

   // R2
   cmp_hi_only_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_cmp_hi |=> $stable(cmp_q));

   // R2
   cmp_lo_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_cmp_lo |=> cmp_q == {$past(hold_q), $past(bus_wdata)});

endmodule

// File: rtl/tcc_counter.sv
module tcc_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             cnt_wr,
   input  logic [CNT_W-1:0] cnt_wdata,
   output logic [CNT_W-1:0] cnt,
   output logic             cmp_en
);

   if (CNT_W < 2) begin : g_bad_cnt
      $error("tcc_counter: CNT_W too small");
   end

   logic [CNT_W-1:0] cnt_q;
   logic             blk_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (cnt_wr) begin
         cnt_q <= cnt_wdata;
      end else if (tick) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   // suppression armed by a load, spent by the first tick after it
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         blk_q <= 1'b0;
      end else if (cnt_wr) begin
         blk_q <= 1'b1;
      end else if (tick) begin
         blk_q <= 1'b0;
      end
   end

   assign cnt    = cnt_q;
   assign cmp_en = tick && !cnt_wr && !blk_q;

   // R3
   cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !cnt_wr) |=> cnt_q == $past(cnt_q) + 1'b1);

   // R3
   cnt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !cnt_wr) |=> $stable(cnt_q));

endmodule

// File: rtl/tcc_match.sv
module tcc_match #(
   parameter int CNT_W     = 16,
   parameter int LANE_W    = 8,
   parameter bit SPLIT_CMP = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] cnt,
   input  logic [CNT_W-1:0] cmp_val,
   input  logic             cmp_en,
   input  logic             flag_clr,
   output logic             hit,
   output logic             flag
);

   localparam int LANES = (CNT_W + LANE_W - 1) / LANE_W;

   if (CNT_W % LANE_W != 0) begin : g_bad_lane
      $error("tcc_match: CNT_W must be a multiple of LANE_W");
   end

   logic eq;

   if (SPLIT_CMP) begin : g_split
      logic [LANES-1:0] lane_eq;
      for (genvar i = 0; i < LANES; i++) begin : g_lane
         assign lane_eq[i] = cnt[i*LANE_W +: LANE_W] == cmp_val[i*LANE_W +: LANE_W];
      end
      assign eq = &lane_eq;
   end else begin : g_flat
      assign eq = cnt == cmp_val;
   end

   assign hit = cmp_en && eq;

   logic flag_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
      end else if (hit) begin
         flag_q <= 1'b1;
      end else if (flag_clr) begin
         flag_q <= 1'b0;
      end
   end

   assign flag = flag_q;

   // R5
   flag_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_q) |-> $past(cmp_en && (cnt == cmp_val)));

   // R6
   flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_clr && !hit) |=> !flag_q);

endmodule

// File: rtl/tcc_wave.sv
module tcc_wave
   import tcc_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic hit,
   input  logic force_stb,
   input  ocm_e mode,
   output logic wave
);

   logic wave_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wave_q <= 1'b0;
      end else if (hit || force_stb) begin
         wave_q <= ocm_apply(mode, wave_q);
      end
   end

   assign wave = wave_q;

   // R7
   wave_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && mode == OCM_SET) |=> wave_q);

   // R7
   wave_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && mode == OCM_CLEAR) |=> !wave_q);

   // R8
   wave_force_tgl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (force_stb && mode == OCM_TOGGLE) |=> wave_q != $past(wave_q));

   // R11
   wave_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!hit && !force_stb) |=> $stable(wave_q));

endmodule

// File: rtl/tmr_cmp_chan.sv
module tmr_cmp_chan
   import tcc_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int CNT_W     = 16,
   parameter bit SPLIT_CMP = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic [REG_AW-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              cmp_flag,
   output logic              wave_out
);

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] cmp_val;
   logic [CNT_W-1:0] cnt_wdata;
   ocm_e             eff_mode;
   logic             cnt_wr, force_stb, flag_clr, cmp_en, hit, flag;

   tcc_regif #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_regif (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_wr    (bus_wr),
      .bus_rd    (bus_rd),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .cnt       (cnt),
      .flag      (flag),
      .cmp_val   (cmp_val),
      .eff_mode  (eff_mode),
      .cnt_wr    (cnt_wr),
      .cnt_wdata (cnt_wdata),
      .force_stb (force_stb),
      .flag_clr  (flag_clr)
   );

   tcc_counter #(.CNT_W(CNT_W)) u_counter (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .cnt_wr    (cnt_wr),
      .cnt_wdata (cnt_wdata),
      .cnt       (cnt),
      .cmp_en    (cmp_en)
   );

   tcc_match #(.CNT_W(CNT_W), .LANE_W(DATA_W), .SPLIT_CMP(SPLIT_CMP)) u_match (
      .clk      (clk),
      .rst_n    (rst_n),
      .cnt      (cnt),
      .cmp_val  (cmp_val),
      .cmp_en   (cmp_en),
      .flag_clr (flag_clr),
      .hit      (hit),
      .flag     (flag)
   );

   tcc_wave u_wave (
      .clk       (clk),
      .rst_n     (rst_n),
      .hit       (hit),
      .force_stb (force_stb),
      .mode      (eff_mode),
      .wave      (wave_out)
   );

   assign cmp_flag = flag;

   // R9
   no_match_after_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag) |-> !$past(cnt_wr));

   // R8
   force_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (force_stb && !hit && !flag) |=> !flag);

endmodule

// File: tb/tmr_cmp_chan_test.sv
`timescale 1ns/1ps
module tmr_cmp_chan_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic [2:0] bus_addr = '0;
   logic       bus_wr = 1'b0;
   logic       bus_rd = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic       cmp_flag, wave_out;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   tmr_cmp_chan uut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .bus_addr(bus_addr),
      .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .cmp_flag(cmp_flag), .wave_out(wave_out)
   );

   task automatic check(input string req, input string what, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, input bit strobe, output logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_rd = strobe;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic wr16(input logic [2:0] lo_addr, input logic [15:0] v);
      wr(lo_addr + 3'd1, v[15:8]);
      wr(lo_addr, v[7:0]);
   endtask

   task automatic rd_cnt(output logic [15:0] v);
      logic [7:0] lo, hi;
      rd(3'd0, 1'b1, lo);
      rd(3'd1, 1'b0, hi);
      v = {hi, lo};
   endtask

   task automatic ticks(input int n);
      @(negedge clk);
      tick = 1'b1;
      repeat (n) @(negedge clk);
      tick = 1'b0;
   endtask

   task automatic clr_flag();
      wr(3'd5, 8'h01);
   endtask

   // load count to cmp-1: first tick is suppressed, second matches
   task automatic one_match(input logic [15:0] cmpv);
      wr16(3'd0, cmpv - 16'd1);
      ticks(2);
   endtask

   task automatic t_reset();
      logic [7:0] d;
      for (int a = 0; a < 6; a++) begin
         rd(3'(a), 1'b0, d);
         check("R1", $sformatf("reg %0d after reset", a), d, 0);
      end
      check("R1", "flag after reset", cmp_flag, 0);
      check("R1", "wave after reset", wave_out, 0);
   endtask

   task automatic t_cmp_load();
      logic [7:0] d;
      wr16(3'd2, 16'h0010);
      wr(3'd3, 8'hAB);
      rd(3'd3, 1'b0, d);
      check("R2", "cmp hi before low write", d, 8'h00);
      wr(3'd2, 8'hCD);
      rd(3'd3, 1'b0, d);
      check("R2", "cmp hi after low write", d, 8'hAB);
      rd(3'd2, 1'b0, d);
      check("R2", "cmp lo after low write", d, 8'hCD);
      wr(3'd3, 8'h12);
      wr(3'd1, 8'h34);
      wr(3'd2, 8'h56);
      rd(3'd3, 1'b0, d);
      check("R2", "shared holding byte", d, 8'h34);
   endtask

   task automatic t_count();
      logic [15:0] v;
      wr16(3'd0, 16'h0100);
      ticks(3);
      rd_cnt(v);
      check("R3", "count after 3 ticks", v, 16'h0103);
      repeat (4) @(negedge clk);
      rd_cnt(v);
      check("R3", "count holds without tick", v, 16'h0103);
      wr16(3'd0, 16'hFFFF);
      ticks(1);
      rd_cnt(v);
      check("R3", "wrap to zero", v, 16'h0000);
   endtask

   task automatic t_count_read();
      logic [7:0] lo, hi;
      wr16(3'd0, 16'h12FF);
      rd(3'd0, 1'b1, lo);
      check("R4", "live low byte", lo, 8'hFF);
      ticks(1);
      rd(3'd1, 1'b0, hi);
      check("R4", "latched high byte", hi, 8'h12);
      rd(3'd0, 1'b1, lo);
      rd(3'd1, 1'b0, hi);
      check("R4", "fresh count", {hi, lo}, 16'h1300);
   endtask

   task automatic t_flag();
      logic [7:0] d;
      wr16(3'd2, 16'h0005);
      wr16(3'd0, 16'h0000);
      ticks(5);
      check("R5", "no flag before equal tick", cmp_flag, 0);
      repeat (3) @(negedge clk);
      check("R5", "equality without tick", cmp_flag, 0);
      ticks(1);
      check("R5", "flag after matching tick", cmp_flag, 1);
      rd(3'd5, 1'b0, d);
      check("R5", "status bit 0", d, 8'h01);
      wr(3'd5, 8'h00);
      check("R6", "write 0 keeps flag", cmp_flag, 1);
      clr_flag();
      check("R6", "write 1 clears flag", cmp_flag, 0);
   endtask

   task automatic t_modes();
      wr16(3'd2, 16'h0040);
      wr(3'd4, 8'h03);
      one_match(16'h0040);
      check("R7", "mode 11 sets", wave_out, 1);
      check("R5", "flag on match", cmp_flag, 1);
      clr_flag();
      wr(3'd4, 8'h00);
      check("R11", "mode change keeps wave", wave_out, 1);
      one_match(16'h0040);
      check("R7", "mode 00 leaves wave", wave_out, 1);
      clr_flag();
      wr(3'd4, 8'h01);
      one_match(16'h0040);
      check("R7", "mode 01 toggles low", wave_out, 0);
      one_match(16'h0040);
      check("R7", "mode 01 toggles high", wave_out, 1);
      clr_flag();
      wr(3'd4, 8'h02);
      check("R11", "mode write alone keeps wave", wave_out, 1);
      one_match(16'h0040);
      check("R7", "mode 10 clears", wave_out, 0);
      clr_flag();
   endtask

   task automatic t_immediate_mode();
      // action written in the same clock as the matching tick
      wr16(3'd2, 16'h0070);
      wr(3'd4, 8'h02);
      wr16(3'd0, 16'h006F);
      ticks(1);
      @(negedge clk);
      bus_addr = 3'd4; bus_wdata = 8'h03; bus_wr = 1'b1; tick = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0; tick = 1'b0;
      check("R11", "new action used at once", wave_out, 1);
      clr_flag();
   endtask

   task automatic t_force();
      logic [15:0] v;
      logic [7:0]  d;
      wr16(3'd0, 16'h0200);
      wr(3'd4, 8'h06);
      check("R8", "force clear", wave_out, 0);
      check("R8", "force leaves flag", cmp_flag, 0);
      rd(3'd4, 1'b0, d);
      check("R8", "force bit reads 0", d, 8'h02);
      rd_cnt(v);
      check("R8", "force leaves count", v, 16'h0200);
      wr(3'd4, 8'h05);
      check("R8", "force toggle", wave_out, 1);
   endtask

   task automatic t_block();
      wr16(3'd2, 16'h0010);
      wr16(3'd0, 16'h0010);
      repeat (5) @(negedge clk);
      ticks(1);
      check("R9", "tick after load blocked despite idle", cmp_flag, 0);
      wr16(3'd0, 16'h000F);
      ticks(2);
      check("R9", "second tick compares", cmp_flag, 1);
      clr_flag();
   endtask

   task automatic t_lost();
      wr16(3'd2, 16'h0010);
      wr16(3'd0, 16'h0010);
      ticks(1);
      check("R10", "match equal to load lost", cmp_flag, 0);
      ticks(65535);
      check("R10", "no match before full cycle", cmp_flag, 0);
      ticks(1);
      check("R10", "match after full cycle", cmp_flag, 1);
      clr_flag();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_cmp_load();
      t_count();
      t_count_read();
      t_flag();
      t_modes();
      t_immediate_mode();
      t_force();
      t_block();
      t_lost();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (150000) @(posedge clk);
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule